// File: doc/BRIEF.md
# SPI Receive Status, Overflow and Service Request Logic

This block holds the receive-side status of a serial peripheral interface controller. It sits between the shift register, which reports each finished byte with a one-cycle strobe, and the reader of the received data. That reader is either the processor or a DMA engine. The block keeps the receive data register, a receive-full flag and an overflow flag. It also keeps a small control register that enables the receive interrupt, routes receive-full service to DMA instead of the processor, and enables the error interrupt.

A byte is taken into the data register only while the register is empty and no overflow is pending. A byte that arrives while the register is still full is dropped and raises the overflow flag. From then on the data register is frozen and no DMA service request is issued until software clears the overflow. The overflow flag can be gated onto the interrupt line, so that a processor waiting on a DMA byte count that can no longer be reached is woken.

The processor clears each flag in two steps: a status read that sees the flag set, then a data read. A DMA data read clears the receive-full flag directly.

Top module: `spi_rx_status`

## Requirements
- R1: A byte-done strobe while receive-full and overflow are both clear copies the shift byte into the data register and sets receive-full on the next cycle.
- R2: A DMA data read while receive-full is set clears receive-full.
- R3: A byte-done strobe while receive-full is set, with no clearing read in the same cycle, sets the overflow flag and leaves the data register unchanged.
- R4: While overflow is set, byte-done strobes change neither the data register nor receive-full.
- R5: The DMA request equals receive-full AND DMA-select AND NOT overflow.
- R6: A processor data read clears receive-full only if an earlier status read saw receive-full set. A data read with no such status read leaves the flag set.
- R7: Overflow clears only on a processor data read that follows a status read which saw overflow set. An overflow that arises after the status read survives the data read.
- R8: The interrupt output equals (receive-full AND receive-interrupt enable AND NOT DMA-select) OR (overflow AND error-interrupt enable). Control write data bit 0 is the receive-interrupt enable, bit 1 is DMA-select and bit 2 is the error-interrupt enable.
- R9: A byte-done strobe in the same cycle as a read that clears receive-full loads the new byte, keeps receive-full set and does not set overflow.
- R10: Reset clears both flags and all control bits, and deasserts the DMA request and the interrupt.
- R11: A byte-done strobe in the cycle that clears overflow is lost. The next strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_done | input | 1 | One-cycle strobe: the shift register holds a finished byte |
| shift_byte | input | DATA_W | Byte from the shift register |
| cpu_rd_stat | input | 1 | Processor read of the status register |
| cpu_rd_data | input | 1 | Processor read of the data register |
| dma_rd_data | input | 1 | DMA read of the data register |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 3 | Control value: bit 0 receive-interrupt enable, bit 1 DMA-select, bit 2 error-interrupt enable |
| rx_data | output | DATA_W | Receive data register |
| stat_full | output | 1 | Receive-full flag |
| stat_ovf | output | 1 | Overflow flag |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt request |

## Verification
Byte arrival can fall in the same cycle as the read that empties the data register. The bench drives a byte-done strobe together with a DMA data read while the register is full. It judges the result by a loaded new byte, a flag that is still set, and no overflow. A second collision puts byte arrival in the cycle of the processor data read that clears overflow. There the byte must vanish, and the next byte must load normally.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned CTRL_W = 3;

  typedef struct packed {
    logic err_ie;
    logic dma_sel;
    logic rx_ie;
  } rx_ctrl_t;
endpackage

// File: rtl/rx_clr_seq.sv
module rx_clr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic cpu_rd_stat,
  input  logic cpu_rd_data,
  input  logic dma_rd_data,
  output logic clear_full
);
  logic arm_q, arm_d;

  always_comb begin
    arm_d      = (cpu_rd_stat & full) | (arm_q & ~cpu_rd_data & ~dma_rd_data);
    clear_full = full & (dma_rd_data | (cpu_rd_data & arm_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  // R6 / R2: receive-full only drops after a DMA read or an armed processor read
  p_full_clear_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> ($past(dma_rd_data) || ($past(cpu_rd_data) && $past(arm_q))));
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] shift_byte,
  input  logic              ovf,
  input  logic              clear_full,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ovf_hit
);
  logic              load;
  logic              full_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    load    = byte_done & ~ovf & (~full | clear_full);
    ovf_hit = byte_done & ~ovf & full & ~clear_full;
    full_d  = load | (full & ~clear_full);
    data_d  = load ? shift_byte : data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data <= '0;
    else if (load) data <= data_d;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ovf && !full) |=> (full && data == $past(shift_byte)));
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(data));
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ovf && full && clear_full) |=> full);
endmodule

// File: rtl/rx_ovf.sv
module rx_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_hit,
  input  logic cpu_rd_stat,
  input  logic cpu_rd_data,
  output logic ovf
);
  logic arm_q, arm_d, ovf_d, clr;

  always_comb begin
    arm_d = (cpu_rd_stat & ovf) | (arm_q & ~cpu_rd_data);
    clr   = cpu_rd_data & arm_q;
    if (ovf_hit)  ovf_d = 1'b1;
    else if (clr) ovf_d = 1'b0;
    else          ovf_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      arm_q <= arm_d;
      ovf   <= ovf_d;
    end
  end

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf);
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(cpu_rd_data));
endmodule

// File: rtl/rx_req.sv
module rx_req
  import spi_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     full,
  input  logic     ovf,
  input  rx_ctrl_t ctrl,
  output logic     dma_req,
  output logic     irq
);
  always_comb begin
    dma_req = full & ctrl.dma_sel & ~ovf;
    irq     = (full & ctrl.rx_ie & ~ctrl.dma_sel) | (ovf & ctrl.err_ie);
  end

  p_no_dma_in_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !dma_req);
  p_err_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ctrl.err_ie) |-> irq);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] shift_byte,
  input  logic              cpu_rd_stat,
  input  logic              cpu_rd_data,
  input  logic              dma_rd_data,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              stat_full,
  output logic              stat_ovf,
  output logic              dma_req,
  output logic              irq
);
  rx_ctrl_t ctrl_q, ctrl_d;
  logic     clear_full, ovf_hit;

  always_comb ctrl_d = ctrl_we ? rx_ctrl_t'(ctrl_wdata) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  rx_clr_seq u_clr (
    .clk(clk), .rst_n(rst_n), .full(stat_full), .cpu_rd_stat(cpu_rd_stat),
    .cpu_rd_data(cpu_rd_data), .dma_rd_data(dma_rd_data), .clear_full(clear_full)
  );

  rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .shift_byte(shift_byte),
    .ovf(stat_ovf), .clear_full(clear_full), .full(stat_full), .data(rx_data),
    .ovf_hit(ovf_hit)
  );

  rx_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .ovf_hit(ovf_hit), .cpu_rd_stat(cpu_rd_stat),
    .cpu_rd_data(cpu_rd_data), .ovf(stat_ovf)
  );

  rx_req u_req (
    .clk(clk), .rst_n(rst_n), .full(stat_full), .ovf(stat_ovf), .ctrl(ctrl_q),
    .dma_req(dma_req), .irq(irq)
  );

  p_reset_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!stat_full && !stat_ovf && ctrl_q == '0));
endmodule

// File: tb/spi_rx_status_tb.sv
`timescale 1ns/1ps
module spi_rx_status_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_done, cpu_rd_stat, cpu_rd_data, dma_rd_data, ctrl_we;
  logic [7:0] shift_byte;
  logic [2:0] ctrl_wdata;
  logic [7:0] rx_data;
  logic       stat_full, stat_ovf, dma_req, irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  spi_rx_status #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .shift_byte(shift_byte),
    .cpu_rd_stat(cpu_rd_stat), .cpu_rd_data(cpu_rd_data), .dma_rd_data(dma_rd_data),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rx_data(rx_data),
    .stat_full(stat_full), .stat_ovf(stat_ovf), .dma_req(dma_req), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    byte_done = 0; shift_byte = 0; cpu_rd_stat = 0; cpu_rd_data = 0;
    dma_rd_data = 0; ctrl_we = 0; ctrl_wdata = 0;
  endtask

  task automatic cyc(input logic bd, input logic [7:0] b, input logic rs,
                     input logic rd, input logic dr);
    @(negedge clk);
    byte_done = bd; shift_byte = b; cpu_rd_stat = rs; cpu_rd_data = rd; dma_rd_data = dr;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic wctrl(input logic [2:0] v);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R10 full", stat_full, 0); chk("R10 ovf", stat_ovf, 0);
    chk("R10 dma", dma_req, 0);    chk("R10 irq", irq, 0);
  endtask

  task automatic t_load_dma();
    wctrl(3'b010);
    cyc(1, 8'hA5, 0, 0, 0);
    chk("R1 data", rx_data, 8'hA5); chk("R1 full", stat_full, 1);
    chk("R5 dma on", dma_req, 1);   chk("R8 irq off in dma mode", irq, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R2 full cleared", stat_full, 0); chk("R5 dma off", dma_req, 0);
  endtask

  task automatic t_overflow();
    cyc(1, 8'h11, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0);
    chk("R3 ovf", stat_ovf, 1); chk("R3 data kept", rx_data, 8'h11);
    chk("R5 dma gated", dma_req, 0);
    cyc(1, 8'h33, 0, 0, 0);
    chk("R4 data frozen", rx_data, 8'h11);
    cyc(0, 0, 0, 0, 1);
    chk("R2 full clr in ovf", stat_full, 0);
    cyc(1, 8'h44, 0, 0, 0);
    chk("R4 no load", stat_full, 0); chk("R4 data", rx_data, 8'h11);
    chk("R5 no dma", dma_req, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R7 ovf cleared", stat_ovf, 0);
    cyc(1, 8'h55, 0, 0, 0);
    chk("R1 reload", rx_data, 8'h55); chk("R5 dma back", dma_req, 1);
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic t_cpu_clear();
    wctrl(3'b001);
    cyc(1, 8'h66, 0, 0, 0);
    chk("R8 rx irq", irq, 1); chk("R5 no dma cpu mode", dma_req, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R6 lone data read", stat_full, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R6 cleared", stat_full, 0); chk("R8 irq off", irq, 0);
  endtask

  task automatic t_hidden_ovf();
    cyc(1, 8'h77, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 8'h88, 0, 0, 0);
    chk("R3 ovf mid seq", stat_ovf, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 full cleared", stat_full, 0);
    chk("R7 ovf survives", stat_ovf, 1);
    chk("R3 data", rx_data, 8'h77);
    chk("R8 err masked", irq, 0);
    wctrl(3'b101);
    chk("R8 err irq", irq, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R7 ovf cleared", stat_ovf, 0); chk("R8 irq drop", irq, 0);
  endtask

  task automatic t_same_cycle();
    wctrl(3'b010);
    cyc(1, 8'h99, 0, 0, 0);
    cyc(1, 8'hAA, 0, 0, 1);
    chk("R9 data", rx_data, 8'hAA); chk("R9 full", stat_full, 1);
    chk("R9 no ovf", stat_ovf, 0);
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic t_ovf_clr_collide();
    cyc(1, 8'h01, 0, 0, 0);
    cyc(1, 8'h02, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 8'h03, 0, 1, 0);
    chk("R11 ovf clr", stat_ovf, 0); chk("R11 byte lost", stat_full, 0);
    chk("R11 data", rx_data, 8'h01);
    cyc(1, 8'h04, 0, 0, 0);
    chk("R11 next ok", rx_data, 8'h04); chk("R11 full", stat_full, 1);
  endtask

  task automatic t_reset_mid();
    wctrl(3'b100);
    cyc(1, 8'h10, 0, 0, 0);
    chk("R8 pre-reset irq", irq, 1);
    do_reset();
    t_reset();
    cyc(1, 8'h20, 0, 0, 0);
    cyc(1, 8'h30, 0, 0, 0);
    chk("R10 ovf after", stat_ovf, 1);
    chk("R10 err_ie cleared", irq, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_load_dma();
    t_overflow();
    t_cpu_clear();
    t_hidden_ovf();
    t_same_cycle();
    t_ovf_clr_collide();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule